// File: doc/BRIEF.md
# POST Code Capture and Display

This block watches a simple host I/O write bus and keeps the last byte that was written to the diagnostic port. That byte appears as two hexadecimal digits on two seven-segment outputs. Writes to any other address are ignored. When no further write arrives, the last code stays on the display, so a stalled boot leaves its final checkpoint visible.

Three checkpoint codes, 2Ch, 2Eh and 30h, report a memory failure and carry a 16-bit failure bitmap. After one of these codes, the next two port writes are taken as the bitmap: the high byte first, then the low byte. The display keeps showing the checkpoint while the bitmap is being captured. Once both bytes are held, the display rotates through the checkpoint, the bitmap high byte and the bitmap low byte. Each of the three stays on for `PAUSE_CYC` clock cycles, and the rotation repeats until the next port write.

Top module: `postcode_display`

## Requirements
- R1: A write (`io_wr_i` high at a rising clock edge) to address `PORT_ADDR` (default 0080h) in normal or rotating mode is shown on the outputs right after that edge.
- R2: With `io_wr_i` low, the captured code and mode do not change. Outside rotating mode the display holds indefinitely.
- R3: Each digit is an active-high pattern in bit order {g,f,e,d,c,b,a}. The patterns for 0 to F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71. `seg_hi_o` shows bits 7:4 and `seg_lo_o` shows bits 3:0.
- R4: After a port write of 2Ch, 2Eh or 30h, the next two port writes are stored as the bitmap high byte and then the bitmap low byte. The display keeps showing the checkpoint during this capture.
- R5: Once the low byte is captured, the display shows the checkpoint, then the high byte, then the low byte. Each is shown for `PAUSE_CYC` cycles, starting with the checkpoint on the edge that captured the low byte. The rotation repeats continuously.
- R6: A port write during rotation ends the rotation and is shown as a new checkpoint. If that write is itself a memory-failure code, a new bitmap capture starts.
- R7: Reset (`rst_ni` low) shows 00h and leaves bitmap mode.
- R8: Codes other than 2Ch, 2Eh and 30h (for example 2Dh and 2Fh) do not start a bitmap capture.
- R9: Writes to other addresses do not update the code and are not taken as bitmap bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | ADDR_W | I/O write address |
| io_data_i | input | 8 | I/O write data |
| io_wr_i | input | 1 | Single-cycle write strobe |
| seg_hi_o | output | 7 | Left digit segments {g..a}, active high |
| seg_lo_o | output | 7 | Right digit segments {g..a}, active high |

## Verification
The assertions check the following on every cycle:
- only strobed port writes move the code or the mode;
- a memory-failure code always arms the capture, and other codes never do;
- outside rotation the display equals the latched code;
- the phase sits at the checkpoint whenever rotation is off.

The bench's scenarios cover the rest: the segment patterns, the exact dwell of each phase, the repetition of the rotation, and the exit from and re-entry into capture.

// File: rtl/postcode_pkg.sv
package postcode_pkg;
  typedef enum logic [1:0] {MODE_LIVE, MODE_GET_HI, MODE_GET_LO, MODE_ROTATE} mode_e;
  typedef enum logic [1:0] {PH_CODE, PH_BM_HI, PH_BM_LO} phase_e;

  function automatic logic is_mem_fail(logic [7:0] b);
    return (b == 8'h2C) || (b == 8'h2E) || (b == 8'h30);
  endfunction

  // bit order {g,f,e,d,c,b,a}
  function automatic logic [6:0] hex_to_seg(logic [3:0] n);
    logic [6:0] s;
    case (n)
      4'h0: s = 7'h3F; 4'h1: s = 7'h06; 4'h2: s = 7'h5B; 4'h3: s = 7'h4F;
      4'h4: s = 7'h66; 4'h5: s = 7'h6D; 4'h6: s = 7'h7D; 4'h7: s = 7'h07;
      4'h8: s = 7'h7F; 4'h9: s = 7'h6F; 4'hA: s = 7'h77; 4'hB: s = 7'h7C;
      4'hC: s = 7'h39; 4'hD: s = 7'h5E; 4'hE: s = 7'h79; default: s = 7'h71;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/postcode_capture.sv
module postcode_capture
  import postcode_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [7:0]        io_data_i,
  input  logic              io_wr_i,
  output logic [7:0]        code_o,
  output logic [7:0]        bm_hi_o,
  output logic [7:0]        bm_lo_o,
  output mode_e             mode_o
);
  logic port_wr;
  assign port_wr = io_wr_i && (io_addr_i == PORT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o  <= 8'h00;
      bm_hi_o <= 8'h00;
      bm_lo_o <= 8'h00;
      mode_o  <= MODE_LIVE;
    end else if (port_wr) begin
      unique case (mode_o)
        MODE_GET_HI: begin
          bm_hi_o <= io_data_i;
          mode_o  <= MODE_GET_LO;
        end
        MODE_GET_LO: begin
          bm_lo_o <= io_data_i;
          mode_o  <= MODE_ROTATE;
        end
        default: begin
          code_o <= io_data_i;
          mode_o <= is_mem_fail(io_data_i) ? MODE_GET_HI : MODE_LIVE;
        end
      endcase
    end
  end
endmodule

// File: rtl/postcode_sequencer.sv
module postcode_sequencer
  import postcode_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 25_000_000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  output phase_e phase_o
);
  localparam int unsigned CNT_W = $clog2(PAUSE_CYC > 1 ? PAUSE_CYC : 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAUSE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= PH_CODE;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_o <= PH_CODE;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      unique case (phase_o)
        PH_CODE:  phase_o <= PH_BM_HI;
        PH_BM_HI: phase_o <= PH_BM_LO;
        default:  phase_o <= PH_CODE;
      endcase
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/postcode_hex7.sv
module postcode_hex7
  import postcode_pkg::*;
(
  input  logic [3:0] nibble_i,
  output logic [6:0] seg_o
);
  assign seg_o = hex_to_seg(nibble_i);
endmodule

// File: rtl/postcode_display.sv
module postcode_display
  import postcode_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h80,
  parameter int unsigned PAUSE_CYC = 25_000_000,
  parameter int unsigned N_DIGITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [7:0]        io_data_i,
  input  logic              io_wr_i,
  output logic [6:0]        seg_hi_o,
  output logic [6:0]        seg_lo_o
);
  logic [7:0] code_q, bm_hi_q, bm_lo_q, disp_byte;
  mode_e      mode_q;
  phase_e     phase_q;
  logic [6:0] seg_all [N_DIGITS];

  postcode_capture #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_capture (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .io_addr_i(io_addr_i), .io_data_i(io_data_i), .io_wr_i(io_wr_i),
    .code_o(code_q), .bm_hi_o(bm_hi_q), .bm_lo_o(bm_lo_q), .mode_o(mode_q)
  );

  postcode_sequencer #(.PAUSE_CYC(PAUSE_CYC)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(mode_q == MODE_ROTATE), .phase_o(phase_q)
  );

  always_comb begin
    disp_byte = code_q;
    if (mode_q == MODE_ROTATE) begin
      unique case (phase_q)
        PH_BM_HI: disp_byte = bm_hi_q;
        PH_BM_LO: disp_byte = bm_lo_q;
        default:  disp_byte = code_q;
      endcase
    end
  end

  for (genvar d = 0; d < N_DIGITS; d++) begin : g_digit
    postcode_hex7 u_hex (.nibble_i(disp_byte[d*4 +: 4]), .seg_o(seg_all[d]));
  end

  assign seg_lo_o = seg_all[0];
  assign seg_hi_o = seg_all[N_DIGITS-1];
endmodule

// File: rtl/postcode_display_chk.sv
module postcode_display_chk
  import postcode_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h80
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic [7:0]        io_data_i,
  input logic              io_wr_i,
  input logic [7:0]        code_q,
  input mode_e             mode_q,
  input phase_e            phase_q,
  input logic [7:0]        disp_byte
);
  logic port_wr;
  assign port_wr = io_wr_i && (io_addr_i == PORT_ADDR);

  assert_port_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr && (mode_q == MODE_LIVE || mode_q == MODE_ROTATE) |=> code_q == $past(io_data_i));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_i |=> $stable(code_q) && $stable(mode_q));

  assert_enter_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr && mode_q == MODE_LIVE && is_mem_fail(io_data_i) |=> mode_q == MODE_GET_HI);

  assert_show_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != MODE_ROTATE |-> disp_byte == code_q);

  assert_phase_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != MODE_ROTATE |=> phase_q == PH_CODE);

  assert_exit_rotate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr && mode_q == MODE_ROTATE && !is_mem_fail(io_data_i) |=> mode_q == MODE_LIVE);

  assert_plain_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr && mode_q == MODE_LIVE && !is_mem_fail(io_data_i) |=> mode_q == MODE_LIVE);

  assert_other_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_i && io_addr_i != PORT_ADDR |=> $stable(code_q) && $stable(mode_q));
endmodule

bind postcode_display postcode_display_chk #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .io_addr_i(io_addr_i), .io_data_i(io_data_i),
  .io_wr_i(io_wr_i), .code_q(code_q), .mode_q(mode_q), .phase_q(phase_q),
  .disp_byte(disp_byte)
);

// File: tb/postcode_display_tb_top.sv
module postcode_display_tb_top;
  localparam int unsigned PAUSE = 4;
  localparam int unsigned NVEC = 10;

  // {addr[15:0], data[7:0], expected shown byte[7:0]}
  localparam logic [31:0] VECS [NVEC] = '{
    32'h0080_16_16, 32'h0081_55_16, 32'h0080_A5_A5, 32'h0180_77_A5,
    32'h0080_2D_2D, 32'h0080_2F_2F, 32'h0080_00_00, 32'h0000_80_00,
    32'h0080_FF_FF, 32'h0080_3B_3B
  };
  localparam logic [6:0] PAT [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
    7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic [7:0]  io_data_i = '0;
  logic        io_wr_i = 1'b0;
  logic [6:0]  seg_hi_o, seg_lo_o;
  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  postcode_display #(.ADDR_W(16), .PORT_ADDR(16'h0080), .PAUSE_CYC(PAUSE)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .io_addr_i(io_addr_i), .io_data_i(io_data_i),
    .io_wr_i(io_wr_i), .seg_hi_o(seg_hi_o), .seg_lo_o(seg_lo_o)
  );

  task automatic check_byte(input logic [7:0] exp, input string req);
    logic [13:0] want;
    want = {PAT[exp[7:4]], PAT[exp[3:0]]};
    checks++;
    if ({seg_hi_o, seg_lo_o} !== want) begin
      errors++;
      $display("FAIL %s: segs %h/%h expected %h/%h (byte %h)", req,
               seg_hi_o, seg_lo_o, want[13:7], want[6:0], exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    io_addr_i = a; io_data_i = d; io_wr_i = 1'b1;
    @(negedge clk_i);
    io_wr_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(2);
    check_byte(8'h00, "R7 reset state");
    rst_ni = 1'b1;
    idle(1);

    // R1 R3 R8 R9: table walk
    for (int v = 0; v < NVEC; v++) begin
      bus_wr(VECS[v][31:16], VECS[v][15:8]);
      check_byte(VECS[v][7:0], "R1/R3/R9 vector");
    end

    // R2: data on bus without strobe, then long idle
    @(negedge clk_i);
    io_addr_i = 16'h0080; io_data_i = 8'h99;
    idle(20);
    check_byte(8'h3B, "R2 hold without strobe");

    // R8: 2Dh is not a memory code; next write shows directly
    bus_wr(16'h0080, 8'h2D);
    bus_wr(16'h0080, 8'h12);
    check_byte(8'h12, "R8 no capture after 2D");

    // R4 R9: capture with a foreign write in between
    bus_wr(16'h0080, 8'h2E);
    check_byte(8'h2E, "R4 checkpoint shown");
    bus_wr(16'h0080, 8'h10);
    check_byte(8'h2E, "R4 still checkpoint after high byte");
    bus_wr(16'h0084, 8'hEE);
    check_byte(8'h2E, "R9 foreign write during capture");
    bus_wr(16'h0080, 8'h20);
    // R5: rotation timing, bitmap 1020h
    check_byte(8'h2E, "R5 phase code start");
    idle(PAUSE - 1);
    check_byte(8'h2E, "R5 phase code last cycle");
    idle(1);
    check_byte(8'h10, "R5 phase high byte");
    idle(PAUSE);
    check_byte(8'h20, "R5 phase low byte");
    idle(PAUSE);
    check_byte(8'h2E, "R5 repeat code");
    idle(PAUSE);
    check_byte(8'h10, "R5 repeat high byte");

    // R6: exit with plain code, then stays
    bus_wr(16'h0080, 8'h45);
    check_byte(8'h45, "R6 exit rotation");
    idle(3 * PAUSE);
    check_byte(8'h45, "R6 stays after exit");

    // R6: re-enter via 2Ch during rotation
    bus_wr(16'h0080, 8'h30);
    bus_wr(16'h0080, 8'hAB);
    bus_wr(16'h0080, 8'hCD);
    idle(PAUSE);
    check_byte(8'hAB, "R4 code 30 high byte");
    bus_wr(16'h0080, 8'h2C);
    check_byte(8'h2C, "R6 new memory code in rotation");
    bus_wr(16'h0080, 8'h00);
    bus_wr(16'h0080, 8'h02);
    idle(PAUSE);
    check_byte(8'h00, "R6 new capture high byte");
    idle(PAUSE);
    check_byte(8'h02, "R6 new capture low byte");

    // R7: reset mid-rotation
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check_byte(8'h00, "R7 reset clears");
    rst_ni = 1'b1;
    bus_wr(16'h0080, 8'h77);
    bus_wr(16'h0080, 8'h88);
    check_byte(8'h88, "R7 normal mode after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule